// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer Indirection

This block is the data store of a small 8-bit controller core. It spans a 256-location byte address space. The low 32 addresses hold special-function bytes. Addresses 20H to FFH hold 224 bytes of general-purpose RAM. Special registers owned by other units, such as timers, ports and the accumulator, are kept here only as plain storage bytes. A few holes in the low region hold nothing and always read as zero.

Two addresses, 00H and 02H, have no storage of their own. An access to 00H acts on the location named by the pointer byte at 01H. An access to 02H acts on the location named by the pointer byte at 03H. If the pointer names one of the two phantom addresses, the access does nothing: a read returns zero and a write is dropped. The block has three access paths:

- a combinational read port;
- a byte write port;
- a single-bit set/clear port.

All three paths resolve indirection the same way, within the same cycle.

Top module: `dmem_indirect`

## Requirements
- R1: After reset every address reads 00H.
- R2: A byte written with `wr_en` high is stored at the rising edge. It reads back from that address afterwards. This holds for 20H–FFH and for the plain special bytes.
- R3: The hole addresses 0CH, 18H, 19H, 1AH, 1BH and 1EH always read 00H. Writes to them, direct or indirect, are ignored.
- R4: Address 08H is read-only. It reads 00H and ignores writes and bit operations.
- R5: The pointer bytes at 01H (pointer A) and 03H (pointer B) are full 8-bit read/write registers.
- R6: A read or write of 00H acts on the address held in pointer A. A read or write of 02H acts on the address held in pointer B. The same hole and read-only rules apply to the resolved address.
- R7: If a pointer holds 00H or 02H, an indirect read returns 00H and an indirect write changes nothing.
- R8: With `bit_en` high, bit `bit_idx` (0 = LSB, 7 = MSB) of the resolved `bit_addr` is set to `bit_val` at the rising edge. The other seven bits keep their values.
- R9: A bit operation aimed at a hole, the read-only byte, or a phantom target changes nothing.
- R10: When `wr_en` and `bit_en` are both high in the same cycle, only the byte write happens and the bit operation is dropped.
- R11: `rd_data` follows `rd_addr` and the stored contents combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 8 | Read address (00H/02H indirect) |
| rd_data | output | 8 | Read data |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| bit_en | input | 1 | Bit operation enable |
| bit_addr | input | 8 | Bit operation address |
| bit_idx | input | 3 | Bit position, 0 = LSB |
| bit_val | input | 1 | 1 sets the bit, 0 clears it |

## Verification
A wrong pointer value shows on the very next read of 00H or 02H. It also shows one cycle later as a write or bit change landing at the wrong address, which a read of the intended address then exposes. A hole or the read-only byte that wrongly takes a value is seen on the first read of that address. Any value leaking through a phantom target appears as a nonzero indirect read. Randomised mixed traffic that is heavy on the low 32 addresses keeps these checks running against a reference model at every step.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] SLOT_A   = 8'h00;
    localparam logic [ADDR_W-1:0] PTR_A    = 8'h01;
    localparam logic [ADDR_W-1:0] SLOT_B   = 8'h02;
    localparam logic [ADDR_W-1:0] PTR_B    = 8'h03;
    localparam logic [ADDR_W-1:0] TBL_HI   = 8'h08;
    localparam logic [ADDR_W-1:0] GPR_BASE = 8'h20;

    typedef enum logic [1:0] {
        LOC_PHANTOM,
        LOC_HOLE,
        LOC_RDONLY,
        LOC_PLAIN
    } loc_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] eff;
        logic              rd_ok;
        logic              wr_ok;
    } resolved_t;

    function automatic loc_kind_e kind_of(input logic [ADDR_W-1:0] a);
        if (a >= GPR_BASE)                         return LOC_PLAIN;
        if (a == SLOT_A || a == SLOT_B)            return LOC_PHANTOM;
        if (a == TBL_HI)                           return LOC_RDONLY;
        if (a == 8'h0C || a == 8'h1E)              return LOC_HOLE;
        if (a >= 8'h18 && a <= 8'h1B)              return LOC_HOLE;
        return LOC_PLAIN;
    endfunction

endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr_a,
    input  logic [AW-1:0] ptr_b,
    output resolved_t     res
);
    logic [AW-1:0] eff;
    loc_kind_e     kind;

    always_comb begin
        if (addr == SLOT_A)      eff = ptr_a;
        else if (addr == SLOT_B) eff = ptr_b;
        else                     eff = addr;
        kind      = kind_of(eff);
        res.eff   = eff;
        res.rd_ok = (kind == LOC_PLAIN) || (kind == LOC_RDONLY);
        res.wr_ok = (kind == LOC_PLAIN);
    end
endmodule

// File: rtl/dmem_store.sv
module dmem_store
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int ND = 1 << AW,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_eff,
    input  logic [DW-1:0] wr_data,
    input  logic          bit_go,
    input  logic [AW-1:0] bit_eff,
    input  logic [BW-1:0] bit_idx,
    input  logic          bit_val,
    input  logic [AW-1:0] rd_eff,
    output logic [DW-1:0] rd_word,
    output logic [AW-1:0] ptr_a,
    output logic [AW-1:0] ptr_b
);
    typedef struct packed {
        logic [ND-1:0][DW-1:0] mem;
    } store_t;

    store_t s_d, s_q;
    logic [DW-1:0] rmw;

    always_comb begin
        s_d = s_q;
        rmw = s_q.mem[bit_eff];
        rmw[bit_idx] = bit_val;
        if (wr_go) begin
            s_d.mem[wr_eff] = wr_data;
        end else if (bit_go) begin
            s_d.mem[bit_eff] = rmw;
        end
        for (int i = 0; i < ND; i++) begin
            if (kind_of(AW'(i)) != LOC_PLAIN) s_d.mem[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_word = s_q.mem[rd_eff];
    assign ptr_a   = AW'(s_q.mem[PTR_A]);
    assign ptr_b   = AW'(s_q.mem[PTR_B]);
endmodule

// File: rtl/dmem_indirect.sv
module dmem_indirect
    import dmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          bit_en,
    input  logic [AW-1:0] bit_addr,
    input  logic [BW-1:0] bit_idx,
    input  logic          bit_val
);
    logic [AW-1:0] ptr_a_w, ptr_b_w;
    logic [DW-1:0] rd_word;
    resolved_t     rd_res, wr_res, bit_res;

    dmem_resolve #(.AW(AW)) u_rd_res (
        .addr(rd_addr), .ptr_a(ptr_a_w), .ptr_b(ptr_b_w), .res(rd_res));
    dmem_resolve #(.AW(AW)) u_wr_res (
        .addr(wr_addr), .ptr_a(ptr_a_w), .ptr_b(ptr_b_w), .res(wr_res));
    dmem_resolve #(.AW(AW)) u_bit_res (
        .addr(bit_addr), .ptr_a(ptr_a_w), .ptr_b(ptr_b_w), .res(bit_res));

    dmem_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_en && wr_res.wr_ok),
        .wr_eff  (wr_res.eff),
        .wr_data (wr_data),
        .bit_go  (!wr_en && bit_en && bit_res.wr_ok),
        .bit_eff (bit_res.eff),
        .bit_idx (bit_idx),
        .bit_val (bit_val),
        .rd_eff  (rd_res.eff),
        .rd_word (rd_word),
        .ptr_a   (ptr_a_w),
        .ptr_b   (ptr_b_w)
    );

    assign rd_data = rd_res.rd_ok ? rd_word : '0;
endmodule

// File: rtl/dmem_indirect_chk.sv
module dmem_indirect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       bit_en,
    input logic [7:0] bit_addr,
    input logic [7:0] ptr_a,
    input logic [7:0] ptr_b
);
    p_hole_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'h0C || rd_addr == 8'h1E || (rd_addr >= 8'h18 && rd_addr <= 8'h1B))
        |-> rd_data == 8'h00);

    p_rdonly_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == 8'h08 |-> rd_data == 8'h00);

    p_ptr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == 8'h01 |=> ptr_a == $past(wr_data));

    p_phantom_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'h00 && (ptr_a == 8'h00 || ptr_a == 8'h02)) ||
        (rd_addr == 8'h02 && (ptr_b == 8'h00 || ptr_b == 8'h02))
        |-> rd_data == 8'h00);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && bit_en && bit_addr == 8'h03 && wr_addr > 8'h03
        |=> ptr_b == $past(ptr_b));
endmodule

bind dmem_indirect dmem_indirect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_en(bit_en), .bit_addr(bit_addr), .ptr_a(ptr_a_w), .ptr_b(ptr_b_w)
);

// File: tb/dmem_indirect_test.sv
module dmem_indirect_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       wr_en = 0;
    logic [7:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       bit_en = 0;
    logic [7:0] bit_addr = 0;
    logic [2:0] bit_idx = 0;
    logic       bit_val = 0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] m [256];

    always #5 clk = ~clk;

    dmem_indirect uut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bit_en(bit_en), .bit_addr(bit_addr), .bit_idx(bit_idx), .bit_val(bit_val)
    );

    function automatic bit is_hole(input logic [7:0] a);
        return a == 8'h0C || a == 8'h1E || (a >= 8'h18 && a <= 8'h1B);
    endfunction

    function automatic logic [7:0] resolve(input logic [7:0] a);
        if (a == 8'h00) return m[1];
        if (a == 8'h02) return m[3];
        return a;
    endfunction

    function automatic bit storable(input logic [7:0] e);
        return !(e == 8'h00 || e == 8'h02 || e == 8'h08 || is_hole(e));
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] e = resolve(a);
        return storable(e) ? m[e] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        rd_addr = a;
        #1;
        check(req, rd_data, model_read(a));
    endtask

    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit be, input logic [7:0] ba, input logic [2:0] bi, input bit bv);
        logic [7:0] we_eff, be_eff, tmp;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        bit_en = be; bit_addr = ba; bit_idx = bi; bit_val = bv;
        @(posedge clk);
        we_eff = resolve(wa);
        be_eff = resolve(ba);
        if (we) begin
            if (storable(we_eff)) m[we_eff] = wd;
        end else if (be && storable(be_eff)) begin
            tmp = m[be_eff];
            tmp[bi] = bv;
            m[be_eff] = tmp;
        end
        #1;
        wr_en = 0; bit_en = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 200000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=<200000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents
        for (int i = 0; i < 256; i++) begin
            rd_addr = 8'(i); #1; check("R1", rd_data, 8'h00);
        end
        // R2 direct write to RAM and a plain special byte
        step(1, 8'h40, 8'h55, 0, 0, 0, 0);
        rd_addr = 8'h40; #1; check("R2", rd_data, 8'h55);
        step(1, 8'h05, 8'hA3, 0, 0, 0, 0);
        rd_addr = 8'h05; #1; check("R2", rd_data, 8'hA3);
        step(1, 8'hFF, 8'h3C, 0, 0, 0, 0);
        rd_addr = 8'hFF; #1; check("R2", rd_data, 8'h3C);
        // R3 hole, R4 read-only
        step(1, 8'h0C, 8'hFF, 0, 0, 0, 0);
        rd_addr = 8'h0C; #1; check("R3", rd_data, 8'h00);
        step(1, 8'h08, 8'hFF, 0, 0, 0, 0);
        rd_addr = 8'h08; #1; check("R4", rd_data, 8'h00);
        step(0, 0, 0, 1, 8'h08, 3'd2, 1);
        rd_addr = 8'h08; #1; check("R4", rd_data, 8'h00);
        // R5 pointers, R6 indirect
        step(1, 8'h01, 8'h40, 0, 0, 0, 0);
        rd_addr = 8'h01; #1; check("R5", rd_data, 8'h40);
        rd_addr = 8'h00; #1; check("R6", rd_data, 8'h55);
        step(1, 8'h03, 8'h1B, 0, 0, 0, 0);
        step(1, 8'h02, 8'h99, 0, 0, 0, 0);
        rd_addr = 8'h1B; #1; check("R3", rd_data, 8'h00);
        step(1, 8'h00, 8'h66, 0, 0, 0, 0);
        rd_addr = 8'h40; #1; check("R6", rd_data, 8'h66);
        // R7 pointer aimed at a phantom
        step(1, 8'h01, 8'h02, 0, 0, 0, 0);
        step(1, 8'h00, 8'h77, 0, 0, 0, 0);
        rd_addr = 8'h00; #1; check("R7", rd_data, 8'h00);
        rd_addr = 8'h03; #1; check("R7", rd_data, 8'h1B);
        // R8 bit ops, R9 blocked bit ops
        step(0, 0, 0, 1, 8'h40, 3'd7, 1);
        rd_addr = 8'h40; #1; check("R8", rd_data, 8'hE6);
        step(0, 0, 0, 1, 8'h40, 3'd1, 0);
        rd_addr = 8'h40; #1; check("R8", rd_data, 8'hE4);
        step(0, 0, 0, 1, 8'h00, 3'd0, 1);
        rd_addr = 8'h02; #1; check("R9", rd_data, 8'h00);
        step(0, 0, 0, 1, 8'h1E, 3'd4, 1);
        rd_addr = 8'h1E; #1; check("R9", rd_data, 8'h00);
        // R10 write wins over bit op
        step(1, 8'h50, 8'h11, 1, 8'h40, 3'd0, 1);
        rd_addr = 8'h40; #1; check("R10", rd_data, 8'hE4);
        rd_addr = 8'h50; #1; check("R10", rd_data, 8'h11);
        // R11 combinational read between edges
        @(negedge clk);
        rd_addr = 8'h50; #1; check("R11", rd_data, 8'h11);
        rd_addr = 8'h40; #1; check("R11", rd_data, 8'hE4);
        // Random mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a1, a2, a3;
            a1 = ($urandom % 2) ? 8'($urandom % 32) : 8'($urandom);
            a2 = ($urandom % 2) ? 8'($urandom % 32) : 8'($urandom);
            a3 = ($urandom % 2) ? 8'($urandom % 32) : 8'($urandom);
            step(($urandom % 3) == 0, a1, 8'($urandom),
                 ($urandom % 3) == 0, a2, 3'($urandom), 1'($urandom));
            rd_chk(a3, "R6");
            rd_chk(8'($urandom), "R2");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule